// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block generates the addresses of a four-beat burst from one registered address. When a load is requested, it captures the whole external address. Each advance cycle after that moves the internal address to the next beat of the burst. Only the two lowest address bits change. The upper bits keep the value captured at the load until the next load.

A static mode input selects the beat order. In interleaved order the low bits are the start offset XOR a running beat count. In linear order the low bits are the start offset plus the beat count, modulo four. Both orders return to the start offset after four beats and then continue. A clock-enable input can freeze the sequencer for any number of cycles. While it is low, the load and advance inputs are ignored. The current address is driven on the output every cycle, and the memory behind it uses this output.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted, and after it is released with no enabled cycle yet, `burstAddr` is zero.
- R2: A cycle with `clkEn`=1 and `advance`=0 is a load. From the next cycle, `burstAddr` equals the `extAddr` sampled at that edge, and the beat count restarts at zero.
- R3: A cycle with `clkEn`=1 and `advance`=1 is a step. After a step, bits `[ADDR_W-1:2]` of `burstAddr` are unchanged.
- R4: With `interleaveMode`=0 (linear order), after n steps since a load with start offset s, `burstAddr[1:0]` = (s + n) mod 4. For example, start 1 gives 1,2,3,0 and start 3 gives 3,0,1,2.
- R5: With `interleaveMode`=1 (interleaved order), after n steps since a load with start offset s, `burstAddr[1:0]` = s XOR (n mod 4). For example, start 1 gives 1,0,3,2 and start 2 gives 2,3,0,1.
- R6: After the fourth beat the low bits return to the start offset, and stepping continues through the same order without limit.
- R7: In a cycle with `clkEn`=0, `burstAddr` and the beat position do not change, whatever `advance` and `extAddr` are.
- R8: Each step changes bit 0 of `burstAddr` in both orders.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| clkEn | input | 1 | Cycle enable, active high; low freezes all state |
| advance | input | 1 | 0 = load external address, 1 = step to next beat |
| interleaveMode | input | 1 | 1 = interleaved order, 0 = linear order; held static |
| extAddr | input | ADDR_W | External address captured on a load |
| burstAddr | output | ADDR_W | Current internal address |

## Verification
Directed bursts start from every offset in both orders and run past eight beats. These runs tell the linear order from the interleaved order: the two orders agree only for start offsets 0 and 2, so starts 1 and 3 expose a swapped or broken order. Another run stalls in the middle of a burst while toggling `advance` and `extAddr`. This shows whether a frozen cycle leaks into the beat count or the upper bits. A load in the middle of a burst shows whether the count restarts. A random mix of loads, steps and stalls, checked every cycle against a bench model, covers the interleavings in between.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int BEAT_W = 2;

  typedef struct packed {
    logic loadEn;
    logic stepEn;
  } burstStrobes_t;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
(
  input  logic          clkEn,
  input  logic          advance,
  output burstStrobes_t strb
);
  always_comb begin
    strb.loadEn = clkEn & ~advance;
    strb.stepEn = clkEn & advance;
  end
endmodule

// File: rtl/burst_dp.sv
module burst_dp
  import burst_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rstN,
  input  burstStrobes_t     strb,
  input  logic              interleaveMode,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [ADDR_W-1:0] burstAddr
);
  localparam int UPPER_W = ADDR_W - BEAT_W;

  logic [UPPER_W-1:0] upperReg;
  logic [BEAT_W-1:0]  startReg;
  logic [BEAT_W-1:0]  beatCnt;
  logic [BEAT_W-1:0]  linLow;
  logic [BEAT_W-1:0]  intLow;
  logic [BEAT_W-1:0]  curLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upperReg <= '0;
      startReg <= '0;
      beatCnt  <= '0;
    end else if (strb.loadEn) begin
      upperReg <= extAddr[ADDR_W-1:BEAT_W];
      startReg <= extAddr[BEAT_W-1:0];
      beatCnt  <= '0;
    end else if (strb.stepEn) begin
      beatCnt  <= beatCnt + 1'b1;
    end
  end

  // Linear order: modulo add, wraps naturally at the beat width.
  assign linLow = startReg + beatCnt;

  // Interleaved order: per-bit XOR of start offset and beat count.
  for (genvar b = 0; b < BEAT_W; b++) begin : g_intBit
    assign intLow[b] = startReg[b] ^ beatCnt[b];
  end

  assign curLow    = interleaveMode ? intLow : linLow;
  assign burstAddr = {upperReg, curLow};
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic              advance,
  input  logic              interleaveMode,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [ADDR_W-1:0] burstAddr
);
  burstStrobes_t strb;

  burst_ctrl u_ctrl (
    .clkEn   (clkEn),
    .advance (advance),
    .strb    (strb)
  );

  burst_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strb           (strb),
    .interleaveMode (interleaveMode),
    .extAddr        (extAddr),
    .burstAddr      (burstAddr)
  );
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rstN,
  input logic              clkEn,
  input logic              advance,
  input logic              interleaveMode,
  input logic [ADDR_W-1:0] extAddr,
  input logic [ADDR_W-1:0] burstAddr
);
  assert_reset_zero_R1: assert property (@(posedge clk)
    !rstN |-> burstAddr == '0);

  assert_load_capture_R2: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && !advance) |=> burstAddr == $past(extAddr));

  assert_upper_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && advance) |=> burstAddr[ADDR_W-1:2] == $past(burstAddr[ADDR_W-1:2]));

  assert_linear_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && advance && !interleaveMode) |=>
      (!$stable(interleaveMode) || burstAddr[1:0] == 2'($past(burstAddr[1:0]) + 2'd1)));

  assert_interleave_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && advance && interleaveMode) |=>
      (!$stable(interleaveMode) ||
       $countones(burstAddr[1:0] ^ $past(burstAddr[1:0])) >= 1));

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEn && $stable(interleaveMode)) |=> $stable(burstAddr) || !$stable(interleaveMode));

  assert_bit0_toggle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && advance) |=> (!$stable(interleaveMode) || burstAddr[0] != $past(burstAddr[0])));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .clkEn          (clkEn),
  .advance        (advance),
  .interleaveMode (interleaveMode),
  .extAddr        (extAddr),
  .burstAddr      (burstAddr)
);

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
  localparam int ADDR_W = 19;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              clkEn = 1'b0;
  logic              advance = 1'b1;
  logic              interleaveMode = 1'b1;
  logic [ADDR_W-1:0] extAddr = '0;
  logic [ADDR_W-1:0] burstAddr;

  int checks = 0;
  int fails = 0;

  // bench model state
  logic [ADDR_W-3:0] mUpper = '0;
  logic [1:0]        mStart = '0;
  logic [1:0]        mCnt = '0;

  burst_addr_seq #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .advance(advance),
    .interleaveMode(interleaveMode), .extAddr(extAddr), .burstAddr(burstAddr)
  );

  always #2 clk = ~clk;

  function automatic logic [1:0] expLow(input logic mode, input logic [1:0] s,
                                        input logic [1:0] n);
    return mode ? (s ^ n) : 2'(s + n);
  endfunction

  function automatic logic [ADDR_W-1:0] expAddr();
    return {mUpper, expLow(interleaveMode, mStart, mCnt)};
  endfunction

  task automatic check(input string req, input logic [ADDR_W-1:0] exp);
    checks++;
    if (burstAddr !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, burstAddr, exp);
    end
  endtask

  // apply inputs, take one edge, update model, check after the edge
  task automatic cyc(input logic en, input logic adv, input logic [ADDR_W-1:0] a,
                     input string req);
    clkEn = en; advance = adv; extAddr = a;
    @(posedge clk);
    if (en && !adv) begin
      mUpper = a[ADDR_W-1:2]; mStart = a[1:0]; mCnt = 2'd0;
    end else if (en && adv) begin
      mCnt = mCnt + 2'd1;
    end
    #1;
    check(req, expAddr());
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [ADDR_W-1:0] a;
    int seed;
    seed = 32'h1234;
    void'($urandom(seed));
    @(posedge clk); #1;
    check("R1 during reset", '0);
    rstN = 1'b1;
    @(posedge clk); #1;
    check("R1 after reset", '0);

    // every start, both orders, past wrap
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        interleaveMode = m[0];
        a = {17'h1A5C3 + 17'(s * 7), 2'(s)};
        cyc(1'b1, 1'b0, a, "R2 load");
        for (int k = 0; k < 9; k++)
          cyc(1'b1, 1'b1, '1, m[0] ? "R5 R6 R3 interleaved step" : "R4 R6 R3 linear step");
      end
    end

    // stall mid-burst with noisy inputs
    interleaveMode = 1'b0;
    cyc(1'b1, 1'b0, 19'h2AAA5, "R2 load");
    cyc(1'b1, 1'b1, '0, "R4 step");
    cyc(1'b0, 1'b0, 19'h7FFFF, "R7 stall load ignored");
    cyc(1'b0, 1'b1, 19'h12345, "R7 stall step ignored");
    cyc(1'b1, 1'b1, '0, "R4 resume after stall");
    // reload mid-burst restarts count
    cyc(1'b1, 1'b0, 19'h00003, "R2 reload mid-burst");
    cyc(1'b1, 1'b1, '0, "R4 step after reload");

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      logic en, adv;
      en  = ($urandom % 8) != 0;
      adv = ($urandom % 5) != 0;
      if (en && !adv) interleaveMode = 1'($urandom);
      cyc(en, adv, ADDR_W'($urandom), "R2 R3 R4 R5 R7 random");
    end

    // mid-run reset
    rstN = 1'b0; #1;
    mUpper = '0; mStart = '0; mCnt = '0;
    check("R1 async reset", '0);
    @(posedge clk); #1;
    rstN = 1'b1;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule